// File: doc/BRIEF.md
# Real-Mode Physical Address Generator

This block sits in the front end of a processor that runs in real-address mode. Each request carries a 16-bit segment value and a 16-bit offset. The block shifts the segment left by four bits and adds the offset to form the physical byte address. It also produces the word-granular bus address bits. No page translation takes place, so the sum is used directly.

Every segment is 64 Kbytes long. An access whose last byte would lie past offset FFFFH is not wrapped. Instead it is suppressed and reported as fault 13.

A small two-state machine tracks the high address lines after reset:
- It starts in `HI_FORCED` on reset.
- While in `HI_FORCED`, code-segment-relative cycles drive bits 31..20 to ones, so the start-up fetch reaches the top of the 4-Gbyte space.
- The transition `far_release` to `HI_RELEASED` is taken on the first far jump or call. The machine stays in `HI_RELEASED` until the next reset.

An interrupt-vector lookup bypasses segmentation and addresses the 4-byte table entry of its vector number.

Top module: `rm_addr_gen`

## Requirements
- R1: For an ordinary access, the physical address equals segment·16 plus the zero-extended offset. The carry into bit 20 is kept, so results run from 00000000H to 0010FFEFH. The linear value is used unchanged as the physical address.
- R2: Results appear on the outputs one clock after the request is sampled. A cycle with neither `acc_req` nor `vec_req` gives `addr_vld`=0 and `fault_vld`=0 one clock later.
- R3: The `acc_size` encoding is 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. The overrun condition is offset + bytes − 1 > FFFFH, evaluated in 17 bits.
- R4: On an overrun, `addr_vld` is 0, `fault_vld` is 1 and `fault_num` is 13. All three appear in the same output cycle as the address the fault refers to. Without a fault, `fault_num` is 0.
- R5: After reset (state `HI_FORCED`), a code-relative access (`code_rel`=1) drives physical bits 31..20 to ones. A data access (`code_rel`=0) is never forced.
- R6: A `far_xfer` pulse releases the forcing from the next request onward. A code access sampled in the same cycle as `far_xfer` is still forced. The release lasts until the next reset.
- R7: `bus_addr` carries physical bits 31..2. Bits 19..2 of the address are passed through. The upper 12 bus bits are all ones when forced and all zeros otherwise, including when bit 20 of the sum is set.
- R8: With `vec_req`=1, the address is `vec_num`·4, which lies in 000H..3FFH. This request is never forced, never faults, and takes priority over `acc_req`.
- R9: Segment F000H with offset FFF0H, fetched as code in `HI_FORCED`, yields FFFFFFF0H, the start of the initialization area.
- R10: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Segmented memory request this cycle |
| seg_val | input | 16 | Segment register value |
| off_val | input | 16 | Offset within the segment |
| acc_size | input | 2 | Access width code (0:1, 1:2, 2/3:4 bytes) |
| code_rel | input | 1 | Request is relative to the code segment |
| far_xfer | input | 1 | Intersegment jump or call executed |
| vec_req | input | 1 | Interrupt-vector table lookup |
| vec_num | input | 8 | Vector number for the lookup |
| phys_addr | output | 32 | Physical byte address |
| bus_addr | output | 30 | Physical address bits 31..2 as driven on the bus |
| addr_vld | output | 1 | Address is valid and the access proceeds |
| fault_vld | output | 1 | Segment overrun; the access is suppressed |
| fault_num | output | 8 | Exception number (13 on overrun, else 0) |

## Verification
Every result is registered exactly once, so the address, the bus bits, the valid flag and the fault are all due on the first rising edge after the request is sampled. The bench applies each request at a falling edge and samples one time unit after the next rising edge, before it drives anything new.

The release of the forcing takes one more edge, because the state register changes at the same edge that captures the request. The bench model therefore applies `far_xfer` only after it has computed the expectation for that cycle. Segments, offsets near the 64-Kbyte end, all four size codes, both code flags and all 256 vectors are swept.

// File: rtl/rm_addr_pkg.sv
`timescale 1ns/1ps
package rm_addr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } acc_size_e;

    typedef enum logic {
        HI_FORCED   = 1'b0,
        HI_RELEASED = 1'b1
    } hi_state_e;

    // index of the last byte touched, relative to the first
    function automatic logic [1:0] last_byte_idx(input logic [1:0] sz);
        logic [1:0] idx;
        unique case (acc_size_e'(sz))
            SZ_BYTE:  idx = 2'd0;
            SZ_WORD:  idx = 2'd1;
            SZ_DWORD: idx = 2'd3;
            SZ_DWALT: idx = 2'd3;
            default:  idx = 2'd3;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/rm_seg_adder.sv
`timescale 1ns/1ps
module rm_seg_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int LIN_W = SEG_W + SHIFT + 1
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [LIN_W-1:0] lin_o
);
    logic [LIN_W-1:0] seg_base;
    logic [LIN_W-1:0] off_ext;

    always_comb begin
        seg_base = {1'b0, seg_i, {SHIFT{1'b0}}};
        off_ext  = {{(LIN_W-OFF_W){1'b0}}, off_i};
        lin_o    = seg_base + off_ext;   // carry into top bit is retained
    end
endmodule

// File: rtl/rm_overrun_chk.sv
`timescale 1ns/1ps
module rm_overrun_chk
    import rm_addr_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] off_i,
    input  logic [1:0]       size_i,
    output logic             overrun_o
);
    logic [OFF_W:0] end_off;

    always_comb begin
        end_off   = {1'b0, off_i} + {{(OFF_W-1){1'b0}}, last_byte_idx(size_i)};
        overrun_o = end_off[OFF_W];
    end
endmodule

// File: rtl/rm_hiline_fsm.sv
`timescale 1ns/1ps
module rm_hiline_fsm
    import rm_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic far_xfer_i,
    output logic forcing_o
);
    hi_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HI_FORCED:   if (far_xfer_i) state_d = HI_RELEASED;  // far_release
            HI_RELEASED: state_d = HI_RELEASED;
            default:     state_d = HI_FORCED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HI_FORCED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            HI_FORCED:   forcing_o = 1'b1;
            HI_RELEASED: forcing_o = 1'b0;
            default:     forcing_o = 1'b1;
        endcase
    end

    // R6: release is sticky until reset
    a_r6_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HI_RELEASED) |=> (state_q == HI_RELEASED));

    // R6: a far transfer while forced leads to the released state
    a_r6_far_releases: assert property (@(posedge clk) disable iff (!rst_n)
        far_xfer_i |=> (state_q == HI_RELEASED));
endmodule

// File: rtl/rm_addr_gen.sv
`timescale 1ns/1ps
module rm_addr_gen
    import rm_addr_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SHIFT     = 4,
    parameter int PADDR_W   = 32,
    parameter int VEC_W     = 8,
    parameter int FAULT_W   = 8,
    parameter int FAULT_NUM = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_req,
    input  logic [SEG_W-1:0]     seg_val,
    input  logic [OFF_W-1:0]     off_val,
    input  logic [1:0]           acc_size,
    input  logic                 code_rel,
    input  logic                 far_xfer,
    input  logic                 vec_req,
    input  logic [VEC_W-1:0]     vec_num,
    output logic [PADDR_W-1:0]   phys_addr,
    output logic [PADDR_W-3:0]   bus_addr,
    output logic                 addr_vld,
    output logic                 fault_vld,
    output logic [FAULT_W-1:0]   fault_num
);
    localparam int HI_LO  = SEG_W + SHIFT;
    localparam int LIN_W  = HI_LO + 1;
    localparam int HI_W   = PADDR_W - HI_LO;
    localparam int BUS_W  = PADDR_W - 2;
    localparam logic [PADDR_W-1:0] MAX_LIN =
        PADDR_W'(((2**SEG_W) - 1) * (2**SHIFT) + (2**OFF_W) - 1);
    localparam logic [PADDR_W-1:0] VEC_TOP = PADDR_W'((2**VEC_W) * 4 - 1);

    logic [LIN_W-1:0]   lin;
    logic               overrun;
    logic               forcing;

    logic               any_req;
    logic               forced_now;
    logic [PADDR_W-1:0] phys_d;
    logic [BUS_W-1:0]   bus_d;
    logic               vld_d, flt_d;

    logic               forced_q;
    logic               vec_q;

    rm_seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg_i (seg_val),
        .off_i (off_val),
        .lin_o (lin)
    );

    rm_overrun_chk #(.OFF_W(OFF_W)) u_ovr (
        .off_i     (off_val),
        .size_i    (acc_size),
        .overrun_o (overrun)
    );

    rm_hiline_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .far_xfer_i (far_xfer),
        .forcing_o  (forcing)
    );

    always_comb begin
        any_req    = acc_req | vec_req;
        forced_now = 1'b0;
        phys_d     = '0;
        flt_d      = 1'b0;
        if (vec_req) begin
            phys_d = {{(PADDR_W-VEC_W-2){1'b0}}, vec_num, 2'b00};
        end else if (acc_req) begin
            forced_now = code_rel & forcing;
            flt_d      = overrun;
            if (forced_now) phys_d = {{HI_W{1'b1}}, lin[HI_LO-1:0]};
            else            phys_d = {{(PADDR_W-LIN_W){1'b0}}, lin};
        end
        vld_d = any_req & ~flt_d;
        bus_d = {{HI_W{forced_now}}, phys_d[HI_LO-1:2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr <= '0;
            bus_addr  <= '0;
            addr_vld  <= 1'b0;
            fault_vld <= 1'b0;
            fault_num <= '0;
            forced_q  <= 1'b0;
            vec_q     <= 1'b0;
        end else begin
            phys_addr <= phys_d;
            bus_addr  <= bus_d;
            addr_vld  <= vld_d;
            fault_vld <= flt_d;
            fault_num <= flt_d ? FAULT_W'(FAULT_NUM) : '0;
            forced_q  <= forced_now;
            vec_q     <= vec_req;
        end
    end

    // R4: a faulting access is never presented as valid, and carries code 13
    a_r4_fault_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> (!addr_vld && fault_num == FAULT_W'(FAULT_NUM)));

    // R3: a single-byte access can never overrun
    a_r3_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !vec_req && acc_size == 2'd0) |=> !fault_vld);

    // R1: unforced segmented addresses stay within the reachable range
    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !forced_q && !vec_q) |-> (phys_addr <= MAX_LIN));

    // R7: unforced bus upper bits are low
    a_r7_bus_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !forced_q) |-> (bus_addr[BUS_W-1:HI_LO-2] == '0));

    // R8: vector lookups stay inside the vector table and never fault
    a_r8_vec_table: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> (addr_vld && !fault_vld && phys_addr <= VEC_TOP));

    // R2: no request, no result
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_req && !vec_req) |=> (!addr_vld && !fault_vld));
endmodule

// File: tb/tb_rm_addr_gen.sv
`timescale 1ns/1ps
module tb_rm_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_req, code_rel, far_xfer, vec_req;
    logic [15:0] seg_val, off_val;
    logic [1:0]  acc_size;
    logic [7:0]  vec_num;
    logic [31:0] phys_addr;
    logic [29:0] bus_addr;
    logic        addr_vld, fault_vld;
    logic [7:0]  fault_num;

    int n_tests = 0;
    int n_fail  = 0;
    bit mdl_forced;
    bit done = 0;

    always #2.5 clk = ~clk;

    rm_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .seg_val(seg_val),
        .off_val(off_val), .acc_size(acc_size), .code_rel(code_rel),
        .far_xfer(far_xfer), .vec_req(vec_req), .vec_num(vec_num),
        .phys_addr(phys_addr), .bus_addr(bus_addr), .addr_vld(addr_vld),
        .fault_vld(fault_vld), .fault_num(fault_num)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        acc_req = 0; vec_req = 0; code_rel = 0; far_xfer = 0;
        seg_val = '0; off_val = '0; acc_size = '0; vec_num = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        // R10: outputs zero in reset
        chk(phys_addr == 0 && bus_addr == 0 && !addr_vld && !fault_vld && fault_num == 0,
            "R10", "reset outputs", {phys_addr[15:0], 7'd0, addr_vld, fault_num}, 32'h0);
        @(negedge clk);
        rst_n = 1;
        mdl_forced = 1;
    endtask

    // one segmented request, checked one clock later
    task automatic seg_acc(input string req, input logic [15:0] s, input logic [15:0] o,
                           input logic [1:0] sz, input bit code, input bit far);
        int unsigned bytes, lin;
        bit flt, frc;
        logic [31:0] e_phys, e_bus;
        @(negedge clk);
        idle_inputs();
        acc_req = 1; seg_val = s; off_val = o; acc_size = sz;
        code_rel = code; far_xfer = far;
        bytes  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        flt    = (o + bytes - 1) > 32'hFFFF;
        lin    = s * 16 + o;
        frc    = code && mdl_forced;
        e_phys = frc ? (32'hFFF0_0000 | (lin & 32'hF_FFFF)) : lin;
        e_bus  = ((frc ? 32'hFFF0_0000 : 32'h0) | (lin & 32'hF_FFFF)) >> 2;
        @(posedge clk);
        if (far) mdl_forced = 0;
        #1;
        chk(fault_vld == flt && addr_vld == !flt, req, "valid/fault",
            {addr_vld, fault_vld}, {!flt, flt});
        chk(fault_num == (flt ? 8'd13 : 8'd0), "R4", "fault number", fault_num,
            flt ? 32'd13 : 32'd0);
        chk(phys_addr == e_phys, req, "physical address", phys_addr, e_phys);
        chk(bus_addr == e_bus[29:0], "R7", "bus address", bus_addr, e_bus);
    endtask

    task automatic vec_acc(input logic [7:0] v, input bit with_acc);
        @(negedge clk);
        idle_inputs();
        vec_req = 1; vec_num = v;
        if (with_acc) begin
            acc_req = 1; code_rel = 1; seg_val = 16'hF000; off_val = 16'hFFFF; acc_size = 2;
        end
        @(posedge clk);
        #1;
        chk(addr_vld && !fault_vld && phys_addr == v * 4 && bus_addr == v,
            "R8", "vector lookup", phys_addr, v * 4);
    endtask

    logic [15:0] segs [6] = '{16'h0000, 16'h0001, 16'h1234, 16'h8000, 16'hF000, 16'hFFFF};
    logic [15:0] offs [8] = '{16'h0000, 16'h0001, 16'h000F, 16'h7FFF,
                              16'hFFFC, 16'hFFFD, 16'hFFFE, 16'hFFFF};

    initial begin
        idle_inputs();
        rst_n = 0;
        do_reset();

        // R9: start-up fetch lands in the initialization area
        seg_acc("R9", 16'hF000, 16'hFFF0, 2'd2, 1'b1, 1'b0);

        // forced phase: R5 for code, R1/R3 for data
        foreach (segs[i]) foreach (offs[j]) for (int sz = 0; sz < 4; sz++) begin
            seg_acc("R5", segs[i], offs[j], 2'(sz), 1'b1, 1'b0);
            seg_acc("R3", segs[i], offs[j], 2'(sz), 1'b0, 1'b0);
        end

        // R8: vector takes priority over a forced code access
        vec_acc(8'hFF, 1'b1);

        // R6: the release arrives one cycle later
        seg_acc("R6", 16'h2000, 16'h0010, 2'd1, 1'b1, 1'b1);
        seg_acc("R6", 16'h2000, 16'h0010, 2'd1, 1'b1, 1'b0);

        // released phase: R1 and R3 with code and data
        foreach (segs[i]) foreach (offs[j]) for (int sz = 0; sz < 4; sz++) begin
            seg_acc("R1", segs[i], offs[j], 2'(sz), 1'b1, 1'b0);
            seg_acc("R3", segs[i], offs[j], 2'(sz), 1'b0, 1'b0);
        end
        // R1: maximum address with carry into bit 20
        seg_acc("R1", 16'hFFFF, 16'hFFFF, 2'd0, 1'b0, 1'b0);

        // R8: full vector sweep
        for (int v = 0; v < 256; v++) vec_acc(8'(v), 1'b0);

        // R2: idle gives no result
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        #1;
        chk(!addr_vld && !fault_vld, "R2", "idle cycle", {addr_vld, fault_vld}, 32'h0);

        // R6: reset brings the forcing back
        do_reset();
        seg_acc("R6", 16'hF000, 16'hFFF0, 2'd0, 1'b1, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule